// File: doc/BRIEF.md
# Sequential Shift-Add Scaling Multiplier

This block scales a signed sample by an unsigned gain in the way an amplitude modulator needs. It takes an 8-bit two's-complement sample and an 8-bit unsigned coefficient and forms their 16-bit product. It then divides the product by 256 and rounds to the nearest integer. The work takes one multiplier bit per clock. The block runs the multiplier bits from the top bit down, and each step doubles the running sum before it adds the sign-extended sample.

A request is a one-cycle `start_i` pulse while the block is idle. The block captures the operands and the clip selection on that edge. `busy_o` stays high for the eight working cycles, and `done_o` pulses for one cycle with the new result. When clip was selected, the rounded value is limited to the symmetric range -8..+8. The result register holds its value until the next completion.

The controller has two states. `ST_IDLE` moves to `ST_RUN` on an accepted start, which also loads the operands. `ST_RUN` stays in `ST_RUN` while the bit counter is below 7. On the step that handles the last bit it returns to `ST_IDLE` and writes the result.

Top module: `shift_add_scaler`

## Requirements
- R1: While `rst_n` is low, and after it is released, `busy_o` and `done_o` are 0 and `result_o` is 0x00.
- R2: A `start_i` pulse sampled while `busy_o` is 0 makes `busy_o` 1 from the next cycle on, and it stays 1 for exactly 8 cycles.
- R3: `done_o` is 1 for exactly one cycle. It rises 8 clock edges after the edge that accepted the start, in the same cycle that `busy_o` falls.
- R4: With clip off, `result_o` at `done_o` equals floor((sample*coef + 128) / 256) as a signed 8-bit value. This is the high byte of the exact 16-bit product, plus one when bit 7 of the low byte is 1.
- R5: At the range ends the result does not wrap. -128 times 255 gives -127 (0x81), 127 times 255 gives 127 (0x7F), and any sample times 0 gives 0.
- R6: With clip on, a rounded value above +8 becomes 0x08, one below -8 becomes 0xF8, and values from -8 to +8 pass unchanged.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. The operands and clip selection are not replaced, the completion timing is unchanged, and no extra `done_o` follows.
- R8: `clip_en_i` is only sampled with an accepted start. A change while busy has no effect on that result.
- R9: `result_o` keeps its value in every cycle in which `done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; accepted only while idle |
| sample_i | input | 8 | Signed sample (two's complement) |
| coef_i | input | 8 | Unsigned gain coefficient |
| clip_en_i | input | 1 | 1 selects limiting of the result to -8..+8 |
| busy_o | output | 1 | High during the eight working cycles |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 8 | Signed rounded (and optionally clipped) result |

## Verification
Take the edge that samples an accepted start as edge 0. `busy_o` is due after edge 0. `done_o` and the new `result_o` are due after edge 8, and `done_o` must fall again after edge 9. Each scenario task drives inputs on a falling edge and then steps one falling edge at a time. It checks `busy_o`, `done_o` and `result_o` at exactly those offsets. The task that probes ignored starts keeps watching for several cycles after the completion to make sure no second pulse appears.

// File: rtl/scaler_pkg.sv
package scaler_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } scaler_state_e;

endpackage

// File: rtl/scaler_ctrl.sv
module scaler_ctrl
    import scaler_pkg::*;
#(
    parameter int COEF_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic load,
    output logic step,
    output logic last
);
    localparam int CNT_W = (COEF_W > 1) ? $clog2(COEF_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(COEF_W - 1);

    scaler_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (load)
                cnt_q <= '0;
            else if (step)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (cnt_q == CNT_LAST) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy = 1'b0;
        load = 1'b0;
        step = 1'b0;
        last = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_RUN: begin
                busy = 1'b1;
                step = 1'b1;
                last = (cnt_q == CNT_LAST);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scaler_accum.sv
module scaler_accum #(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic                         step,
    input  logic [SAMPLE_W-1:0]          sample,
    input  logic [COEF_W-1:0]            coef,
    output logic [SAMPLE_W+COEF_W-1:0]   sum_next
);
    localparam int ACC_W = SAMPLE_W + COEF_W;

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  mcand_q;
    logic [COEF_W-1:0] mult_q;

    // double the partial sum, then add the multiplicand if the current top bit is set
    always_comb begin
        sum_next = {acc_q[ACC_W-2:0], 1'b0};
        if (mult_q[COEF_W-1])
            sum_next = sum_next + mcand_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mcand_q <= '0;
            mult_q  <= '0;
        end else if (load) begin
            acc_q   <= '0;
            mcand_q <= {{COEF_W{sample[SAMPLE_W-1]}}, sample};
            mult_q  <= coef;
        end else if (step) begin
            acc_q  <= sum_next;
            mult_q <= {mult_q[COEF_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/scaler_finish.sv
module scaler_finish #(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 8,
    parameter int CLIP_LIM = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       capture,
    input  logic                       clip_en,
    input  logic [SAMPLE_W+COEF_W-1:0] sum,
    output logic [SAMPLE_W-1:0]        result,
    output logic                       done
);
    localparam int ACC_W = SAMPLE_W + COEF_W;
    localparam logic signed [SAMPLE_W-1:0] LIM_HI = SAMPLE_W'(CLIP_LIM);
    localparam logic signed [SAMPLE_W-1:0] LIM_LO = SAMPLE_W'(-CLIP_LIM);

    logic signed [SAMPLE_W-1:0] rounded;
    logic signed [SAMPLE_W-1:0] limited;

    // high part of the sum, plus one when the top bit of the discarded part is set
    always_comb begin
        rounded = $signed(sum[ACC_W-1:COEF_W]) + $signed({{(SAMPLE_W-1){1'b0}}, sum[COEF_W-1]});
        limited = rounded;
        if (clip_en) begin
            if (rounded > LIM_HI)
                limited = LIM_HI;
            else if (rounded < LIM_LO)
                limited = LIM_LO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= capture;
            if (capture)
                result <= limited;
        end
    end

endmodule

// File: rtl/shift_add_scaler.sv
module shift_add_scaler #(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 8,
    parameter int CLIP_LIM = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [COEF_W-1:0]   coef_i,
    input  logic                clip_en_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [SAMPLE_W-1:0] result_o
);
    localparam int ACC_W = SAMPLE_W + COEF_W;

    logic             load, step, last;
    logic             clip_q;
    logic [ACC_W-1:0] sum_next;

    scaler_ctrl #(.COEF_W(COEF_W)) ctrl_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_i),
        .busy  (busy_o),
        .load  (load),
        .step  (step),
        .last  (last)
    );

    scaler_accum #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W)) accum_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .sample   (sample_i),
        .coef     (coef_i),
        .sum_next (sum_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            clip_q <= 1'b0;
        else if (load)
            clip_q <= clip_en_i;
    end

    scaler_finish #(.SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .CLIP_LIM(CLIP_LIM)) finish_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (step & last),
        .clip_en (clip_q),
        .sum     (sum_next),
        .result  (result_o),
        .done    (done_o)
    );

endmodule

// File: rtl/scaler_chk.sv
module scaler_chk #(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = 8,
    parameter int CLIP_LIM = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start_i,
    input logic                busy_o,
    input logic                done_o,
    input logic [SAMPLE_W-1:0] result_o,
    input logic                clip_q
);
    localparam int LEN_W = $clog2(COEF_W + 2);
    localparam logic signed [SAMPLE_W-1:0] LIM_HI = SAMPLE_W'(CLIP_LIM);
    localparam logic signed [SAMPLE_W-1:0] LIM_LO = SAMPLE_W'(-CLIP_LIM);

    logic [LEN_W-1:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_len <= '0;
        else if (busy_o)
            busy_len <= busy_len + 1'b1;
        else
            busy_len <= '0;
    end

    // R2
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_len == LEN_W'(COEF_W)));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R3
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R6
    clip_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && clip_q) |-> ($signed(result_o) <= LIM_HI && $signed(result_o) >= LIM_LO));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

endmodule

bind shift_add_scaler scaler_chk #(
    .SAMPLE_W (SAMPLE_W),
    .COEF_W   (COEF_W),
    .CLIP_LIM (CLIP_LIM)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o),
    .clip_q   (clip_q)
);

// File: tb/shift_add_scaler_tb_top.sv
`timescale 1ns/1ps
module shift_add_scaler_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] sample_i = '0;
    logic [7:0] coef_i = '0;
    logic       clip_en_i = 1'b0;
    logic       busy_o, done_o;
    logic [7:0] result_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    shift_add_scaler dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .sample_i  (sample_i),
        .coef_i    (coef_i),
        .clip_en_i (clip_en_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .result_o  (result_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model(input logic signed [7:0] s, input logic [7:0] c, input logic ce);
        int p;
        int r;
        p = int'(s) * int'({24'd0, c});
        r = (p + 128) >>> 8;
        if (ce) begin
            if (r > 8) r = 8;
            else if (r < -8) r = -8;
        end
        return r;
    endfunction

    // one request; if disturb is set, a second start with other operands and a
    // flipped clip select is driven in the middle of the busy window
    task automatic run_op(input logic signed [7:0] s, input logic [7:0] c,
                          input logic ce, input logic disturb, input string req);
        int exp;
        exp = model(s, c, ce);
        @(negedge clk);
        sample_i = s; coef_i = c; clip_en_i = ce; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check({req, "/R2 busy after start"}, int'(busy_o), 1);
        check({req, "/R3 no early done"}, int'(done_o), 0);
        for (int k = 1; k <= 7; k++) begin
            if (disturb && k == 3) begin
                sample_i = 8'sd127; coef_i = 8'd255; clip_en_i = ~ce; start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            check({req, "/R2 busy held"}, int'(busy_o), 1);
            check({req, "/R3 done low while busy"}, int'(done_o), 0);
        end
        start_i = 1'b0;
        @(negedge clk);
        check({req, "/R3 done pulse"}, int'(done_o), 1);
        check({req, "/R3 busy fell"}, int'(busy_o), 0);
        check({req, "/R4 result"}, int'($signed(result_o)), exp);
        @(negedge clk);
        check({req, "/R3 done one cycle"}, int'(done_o), 0);
        check({req, "/R9 result held"}, int'($signed(result_o)), exp);
        if (disturb) begin
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                check({req, "/R7 no extra done"}, int'(done_o), 0);
                check({req, "/R7 idle"}, int'(busy_o), 0);
            end
        end
    endtask

    task automatic t_reset();
        #1;
        check("R1 busy in reset", int'(busy_o), 0);
        check("R1 done in reset", int'(done_o), 0);
        check("R1 result in reset", int'(result_o), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", int'(busy_o), 0);
        check("R1 done after reset", int'(done_o), 0);
        check("R1 result after reset", int'(result_o), 0);
    endtask

    task automatic t_products();
        run_op(8'sd100, 8'd128, 1'b0, 1'b0, "R4 pos");
        run_op(-8'sd100, 8'd128, 1'b0, 1'b0, "R4 neg");
        run_op(8'sd1, 8'd128, 1'b0, 1'b0, "R4 half up");
        run_op(-8'sd1, 8'd128, 1'b0, 1'b0, "R4 neg half");
        run_op(-8'sd3, 8'd85, 1'b0, 1'b0, "R4 neg round");
        run_op(8'sd77, 8'd203, 1'b0, 1'b0, "R4 mixed");
        run_op(-8'sd45, 8'd1, 1'b0, 1'b0, "R4 tiny");
    endtask

    task automatic t_extremes();
        run_op(-8'sd128, 8'd255, 1'b0, 1'b0, "R5 min");
        run_op(8'sd127, 8'd255, 1'b0, 1'b0, "R5 max");
        run_op(-8'sd128, 8'd0, 1'b0, 1'b0, "R5 zero coef");
    endtask

    task automatic t_clip();
        run_op(8'sd127, 8'd255, 1'b1, 1'b0, "R6 clip hi");
        run_op(-8'sd128, 8'd255, 1'b1, 1'b0, "R6 clip lo");
        run_op(8'sd8, 8'd255, 1'b1, 1'b0, "R6 at +8");
        run_op(-8'sd36, 8'd64, 1'b1, 1'b0, "R6 -9 to -8");
        run_op(-8'sd20, 8'd100, 1'b1, 1'b0, "R6 inside");
        run_op(8'sd40, 8'd100, 1'b0, 1'b0, "R6 clip off");
    endtask

    task automatic t_ignore();
        run_op(8'sd50, 8'd40, 1'b0, 1'b1, "R7 start while busy");
        run_op(8'sd90, 8'd200, 1'b1, 1'b1, "R8 clip change while busy");
    endtask

    initial begin
        t_reset();
        t_products();
        t_extremes();
        t_clip();
        t_ignore();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule